// File: doc/BRIEF.md
# Private Interrupt Pending Acceptance

This block keeps the pending bits for the 32 private interrupts of one processor. IDs 0 to 15 are software-generated interrupts (SGIs). IDs 16 to 31 belong to 16 peripheral input lines (PPIs), with line `i` mapped to ID `16+i`. Pending bits are set from two sources. The first is a rising edge on a peripheral line that is configured for edge triggering. The second is an SGI request that passes a group check and a non-secure permission check. A register-side clear port removes pending bits. Prioritisation and delivery to the processor happen downstream and are not part of this block.

An SGI request is presented for one cycle with its ID, the group it asks for and a non-secure flag. A two-state gate handles it. In `GATE_IDLE` it waits. A request moves it to `GATE_EVAL`, and the gate stays in `GATE_EVAL` while requests keep arriving back to back. It returns to `GATE_IDLE` in the first cycle with no request. While in `GATE_EVAL`, the captured request is judged against the configuration inputs of that cycle. On the following edge the gate raises a one-cycle response strobe with an accept flag, and it sets the pending bit if the request was accepted.

Top module: `priv_irq_accept`

## Requirements
- R1: While reset is held, and right after it, `pending`, `ppi_level`, `sgi_resp_valid` and `sgi_resp_accept` are all zero.
- R2: `ppi_level[i]` equals the value `ppi_line[i]` had at the previous clock edge.
- R3: If `ppi_line[i]` is 1 at an edge, `ppi_level[i]` is 0 and `trig_edge[i]` is 1, then `pending[16+i]` is 1 after that edge. A falling edge or a steady line sets nothing.
- R4: A line with `trig_edge[i]` = 0 (level-triggered) never sets `pending[16+i]`. Such a line is visible only through `ppi_level`.
- R5: When `pend_clr_valid` is 1 at an edge, every bit set in `pend_clr_mask` is cleared at that edge. If a set and a clear hit the same bit at the same edge, the set wins.
- R6: Every request (`sgi_valid` = 1 at an edge) gets exactly one response: `sgi_resp_valid` is high for one cycle after the second edge following the request. `sgi_resp_accept` gives the verdict. Requests may arrive on consecutive cycles.
- R7: The configured group of SGI n is decoded as follows: `grp_bit[n]`=1 means Non-secure Group 1, `grp_bit[n]`=0 with `grp_mod[n]`=0 means Group 0, and `grp_bit[n]`=0 with `grp_mod[n]`=1 means Secure Group 1. The requested group `sgi_grp` is encoded as 00 for Group 0, 01 for Secure Group 1, 10 for Non-secure Group 1 and 11 for reserved. After R8, a request whose group differs from the configured group is rejected, and so is the reserved code.
- R8: A Secure Group 1 request (01) aimed at an SGI configured as Group 0 is treated as a Group 0 request.
- R9: When `sgi_ns`=1 and `sec_off`=0, the 2-bit field `sgi_ns_acc[2n+1:2n]` of SGI n must be at least 1 for a Group 0 SGI and at least 2 for a Secure Group 1 SGI, or the request is rejected. Non-secure Group 1 SGIs skip this check. When `sec_off`=1 the check is skipped.
- R10: An accepted request sets `pending[id]` at the same edge that raises its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ppi_line | input | 16 | Peripheral input lines (line i is ID 16+i) |
| trig_edge | input | 16 | Per-line trigger mode, 1 = edge, 0 = level |
| grp_bit | input | 16 | Per-SGI group bit |
| grp_mod | input | 16 | Per-SGI group modifier bit |
| sgi_ns_acc | input | 32 | Per-SGI 2-bit non-secure access level, SGI n at bits 2n+1:2n |
| sec_off | input | 1 | 1 = security disabled, skip the non-secure check |
| sgi_valid | input | 1 | SGI request strobe |
| sgi_id | input | 4 | Requested SGI ID |
| sgi_grp | input | 2 | Requested group code |
| sgi_ns | input | 1 | Request comes from the non-secure side |
| pend_clr_valid | input | 1 | Apply the clear mask this cycle |
| pend_clr_mask | input | 32 | Pending bits to clear |
| pending | output | 32 | Pending latch |
| ppi_level | output | 16 | Registered line levels |
| sgi_resp_valid | output | 1 | One-cycle response strobe |
| sgi_resp_accept | output | 1 | Verdict for the strobed response |

## Verification
The assertions assume that every input is at a known value from the first edge after reset. The two-cycle look-back in the response checks also assumes that reset lasts long enough for that history to exist. The bench drives every input from time zero, holds reset for several edges and changes inputs only on the falling clock edge. As a result, the configuration an evaluation uses is stable across the edge that applies it. The random phase changes the group, modifier, access level and security inputs on every cycle. This tests the assumption that a verdict depends on the configuration in the evaluation cycle and not on the configuration at capture.

// File: rtl/priv_irq_pkg.sv
package priv_irq_pkg;

    // Group codes carried by a request and produced by the configuration decode
    typedef enum logic [1:0] {
        GRP_G0  = 2'b00,
        GRP_S1  = 2'b01,
        GRP_NS1 = 2'b10,
        GRP_BAD = 2'b11
    } irq_grp_e;

    typedef enum logic {
        GATE_IDLE = 1'b0,
        GATE_EVAL = 1'b1
    } gate_state_e;

    // Decode the configured group of one SGI from its group and modifier bits
    function automatic irq_grp_e cfg_group(input logic g_bit, input logic m_bit);
        irq_grp_e r;
        if (g_bit)      r = GRP_NS1;
        else if (m_bit) r = GRP_S1;
        else            r = GRP_G0;
        return r;
    endfunction

    // A secure group 1 ask falls back to group 0 when the SGI is group 0
    function automatic irq_grp_e reconcile(input irq_grp_e asked, input irq_grp_e cfg);
        irq_grp_e r;
        if (asked == GRP_S1 && cfg == GRP_G0) r = GRP_G0;
        else                                  r = asked;
        return r;
    endfunction

endpackage

// File: rtl/priv_irq_line_edge.sv
module priv_irq_line_edge #(
    parameter int NUM_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic [NUM_LINES-1:0] edge_mode,
    output logic [NUM_LINES-1:0] level_q,
    output logic [NUM_LINES-1:0] rise_set
);

    // Stored level only moves when the line differs from it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= line_in;
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign rise_set[i] = line_in[i] & ~level_q[i] & edge_mode[i];
    end

endmodule

// File: rtl/priv_irq_sgi_gate.sv
module priv_irq_sgi_gate
    import priv_irq_pkg::*;
#(
    parameter int NUM_SGI = 16,
    localparam int ID_W   = $clog2(NUM_SGI)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [ID_W-1:0]        req_id,
    input  logic [1:0]             req_grp,
    input  logic                   req_ns,
    input  logic [NUM_SGI-1:0]     grp_bits,
    input  logic [NUM_SGI-1:0]     mod_bits,
    input  logic [2*NUM_SGI-1:0]   ns_acc,
    input  logic                   sec_disable,
    output logic [NUM_SGI-1:0]     set_vec,
    output logic                   resp_valid,
    output logic                   resp_accept
);

    gate_state_e       state_q, state_d;
    logic [ID_W-1:0]   cap_id_q;
    irq_grp_e          cap_grp_q;
    logic              cap_ns_q;

    logic [1:0]        acc_fld [NUM_SGI];
    irq_grp_e          cfg_grp, eff_grp;
    logic [1:0]        lvl;
    logic              grp_ok, perm_ok, accept_now;

    for (genvar i = 0; i < NUM_SGI; i++) begin : g_fld
        assign acc_fld[i] = ns_acc[2*i +: 2];
    end

    // State register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= GATE_IDLE;
            cap_id_q  <= '0;
            cap_grp_q <= GRP_G0;
            cap_ns_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                cap_id_q  <= req_id;
                cap_grp_q <= irq_grp_e'(req_grp);
                cap_ns_q  <= req_ns;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_IDLE: state_d = req_valid ? GATE_EVAL : GATE_IDLE;
            GATE_EVAL: state_d = req_valid ? GATE_EVAL : GATE_IDLE;
        endcase
    end

    // Verdict on the captured request using this cycle's configuration
    always_comb begin
        cfg_grp = cfg_group(grp_bits[cap_id_q], mod_bits[cap_id_q]);
        eff_grp = reconcile(cap_grp_q, cfg_grp);
        grp_ok  = (eff_grp == cfg_grp);
        lvl     = acc_fld[cap_id_q];
        perm_ok = 1'b1;
        if (cap_ns_q && !sec_disable) begin
            if (cfg_grp == GRP_G0)      perm_ok = (lvl >= 2'd1);
            else if (cfg_grp == GRP_S1) perm_ok = (lvl >= 2'd2);
        end
        accept_now = (state_q == GATE_EVAL) && grp_ok && perm_ok;
    end

    for (genvar i = 0; i < NUM_SGI; i++) begin : g_set
        assign set_vec[i] = accept_now && (cap_id_q == ID_W'(i));
    end

    // Output register: one strobe per evaluated request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_accept <= 1'b0;
        end else begin
            resp_valid  <= (state_q == GATE_EVAL);
            resp_accept <= accept_now;
        end
    end

    AST_NS_ACCESS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GATE_EVAL && cap_ns_q && !sec_disable && !grp_bits[cap_id_q]
         && acc_fld[cap_id_q] == 2'd0) |=> !resp_accept); // R9

    AST_NS1_NEEDS_NS1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GATE_EVAL && grp_bits[cap_id_q] && cap_grp_q != GRP_NS1)
        |=> !resp_accept); // R7

endmodule

// File: rtl/priv_irq_pend_store.sv
module priv_irq_pend_store #(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] set_vec,
    input  logic               clr_valid,
    input  logic [NUM_IRQ-1:0] clr_mask,
    output logic [NUM_IRQ-1:0] pend_q
);

    logic [NUM_IRQ-1:0] clr_eff;

    assign clr_eff = clr_valid ? clr_mask : '0;

    // Set is applied after clear so it wins on a shared bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_eff) | set_vec;
    end

endmodule

// File: rtl/priv_irq_accept.sv
module priv_irq_accept
    import priv_irq_pkg::*;
#(
    parameter int NUM_SGI = 16,
    parameter int NUM_PPI = 16,
    localparam int NUM_IRQ = NUM_SGI + NUM_PPI,
    localparam int ID_W    = $clog2(NUM_SGI)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PPI-1:0]   ppi_line,
    input  logic [NUM_PPI-1:0]   trig_edge,
    input  logic [NUM_SGI-1:0]   grp_bit,
    input  logic [NUM_SGI-1:0]   grp_mod,
    input  logic [2*NUM_SGI-1:0] sgi_ns_acc,
    input  logic                 sec_off,
    input  logic                 sgi_valid,
    input  logic [ID_W-1:0]      sgi_id,
    input  logic [1:0]           sgi_grp,
    input  logic                 sgi_ns,
    input  logic                 pend_clr_valid,
    input  logic [NUM_IRQ-1:0]   pend_clr_mask,
    output logic [NUM_IRQ-1:0]   pending,
    output logic [NUM_PPI-1:0]   ppi_level,
    output logic                 sgi_resp_valid,
    output logic                 sgi_resp_accept
);

    logic [NUM_PPI-1:0] line_set;
    logic [NUM_SGI-1:0] sgi_set;
    logic [NUM_IRQ-1:0] set_all;

    priv_irq_line_edge #(.NUM_LINES(NUM_PPI)) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (ppi_line),
        .edge_mode (trig_edge),
        .level_q   (ppi_level),
        .rise_set  (line_set)
    );

    priv_irq_sgi_gate #(.NUM_SGI(NUM_SGI)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (sgi_valid),
        .req_id      (sgi_id),
        .req_grp     (sgi_grp),
        .req_ns      (sgi_ns),
        .grp_bits    (grp_bit),
        .mod_bits    (grp_mod),
        .ns_acc      (sgi_ns_acc),
        .sec_disable (sec_off),
        .set_vec     (sgi_set),
        .resp_valid  (sgi_resp_valid),
        .resp_accept (sgi_resp_accept)
    );

    assign set_all = {line_set, sgi_set};

    priv_irq_pend_store #(.NUM_IRQ(NUM_IRQ)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_all),
        .clr_valid (pend_clr_valid),
        .clr_mask  (pend_clr_mask),
        .pend_q    (pending)
    );

    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ppi_level == $past(ppi_line)); // R2

    AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        sgi_resp_valid |-> $past(sgi_valid, 2)); // R6

    AST_ACCEPT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (sgi_resp_valid && sgi_resp_accept) |-> pending[$past(sgi_id, 2)]); // R10

    for (genvar i = 0; i < NUM_PPI; i++) begin : g_chk
        AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
            (ppi_line[i] && !ppi_level[i] && trig_edge[i]) |=> pending[NUM_SGI+i]); // R3

        AST_NO_LEVEL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pending[NUM_SGI+i]) |->
            $past(ppi_line[i] && !ppi_level[i] && trig_edge[i])); // R4
    end

endmodule

// File: tb/priv_irq_accept_bench.sv
module priv_irq_accept_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ppi_line = '0;
    logic [15:0] trig_edge = '0;
    logic [15:0] grp_bit = '0;
    logic [15:0] grp_mod = '0;
    logic [31:0] sgi_ns_acc = '0;
    logic        sec_off = 1'b0;
    logic        sgi_valid = 1'b0;
    logic [3:0]  sgi_id = '0;
    logic [1:0]  sgi_grp = '0;
    logic        sgi_ns = 1'b0;
    logic        pend_clr_valid = 1'b0;
    logic [31:0] pend_clr_mask = '0;
    logic [31:0] pending;
    logic [15:0] ppi_level;
    logic        sgi_resp_valid, sgi_resp_accept;

    always #2.5 clk = ~clk;

    priv_irq_accept u_priv_irq_accept (
        .clk(clk), .rst_n(rst_n), .ppi_line(ppi_line), .trig_edge(trig_edge),
        .grp_bit(grp_bit), .grp_mod(grp_mod), .sgi_ns_acc(sgi_ns_acc),
        .sec_off(sec_off), .sgi_valid(sgi_valid), .sgi_id(sgi_id),
        .sgi_grp(sgi_grp), .sgi_ns(sgi_ns), .pend_clr_valid(pend_clr_valid),
        .pend_clr_mask(pend_clr_mask), .pending(pending), .ppi_level(ppi_level),
        .sgi_resp_valid(sgi_resp_valid), .sgi_resp_accept(sgi_resp_accept)
    );

    // Behavioural reference
    bit [31:0] m_pend;
    bit [15:0] m_lvl;
    bit        m_rv, m_ra;
    bit [6:0]  m_q[$];
    int        n_cmp = 0;
    int        n_bad = 0;
    string     cur_req = "R1";

    function automatic bit judge(int id, int asked, bit ns);
        int cg;
        int fld;
        cg = grp_bit[id] ? 2 : (grp_mod[id] ? 1 : 0);
        if (asked == 1 && cg == 0) asked = 0;   // R8
        if (asked != cg) return 1'b0;           // R7
        if (ns && !sec_off) begin               // R9
            fld = int'((sgi_ns_acc >> (2 * id)) & 32'd3);
            if (cg == 0 && fld < 1) return 1'b0;
            if (cg == 1 && fld < 2) return 1'b0;
        end
        return 1'b1;
    endfunction

    always @(posedge clk or negedge rst_n) begin : model
        bit [31:0] nx;
        bit [6:0]  e;
        if (!rst_n) begin
            m_pend = '0; m_lvl = '0; m_rv = 0; m_ra = 0;
            m_q.delete();
        end else begin
            nx = m_pend;
            if (pend_clr_valid) nx = nx & ~pend_clr_mask;
            for (int i = 0; i < 16; i++)
                if (ppi_line[i] && !m_lvl[i] && trig_edge[i]) nx[16+i] = 1'b1;
            m_rv = 0; m_ra = 0;
            if (m_q.size() > 0) begin
                e = m_q.pop_front();
                m_rv = 1;
                m_ra = judge(int'(e[3:0]), int'(e[5:4]), e[6]);
                if (m_ra) nx[e[3:0]] = 1'b1;
            end
            if (sgi_valid) m_q.push_back({sgi_ns, sgi_grp, sgi_id});
            m_lvl = ppi_line;
            m_pend = nx;
        end
    end

    task automatic cmp();
        n_cmp++;
        if (pending !== m_pend) begin
            n_bad++;
            $display("FAIL %s pending act=%h exp=%h", cur_req, pending, m_pend);
        end
        n_cmp++;
        if (ppi_level !== m_lvl) begin
            n_bad++;
            $display("FAIL R2 ppi_level act=%h exp=%h", ppi_level, m_lvl);
        end
        n_cmp++;
        if (sgi_resp_valid !== m_rv) begin
            n_bad++;
            $display("FAIL R6 resp_valid act=%b exp=%b", sgi_resp_valid, m_rv);
        end
        n_cmp++;
        if (sgi_resp_accept !== m_ra) begin
            n_bad++;
            $display("FAIL %s resp_accept act=%b exp=%b", cur_req, sgi_resp_accept, m_ra);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cmp();
    endtask

    // One request, optional clear of its bit during the evaluation cycle
    task automatic sgi(input int id, input int g, input bit ns, input bit clr_eval);
        sgi_valid = 1; sgi_id = 4'(id); sgi_grp = 2'(g); sgi_ns = ns;
        step();
        sgi_valid = 0;
        if (clr_eval) begin pend_clr_valid = 1; pend_clr_mask = 32'd1 << id; end
        step();
        pend_clr_valid = 0; pend_clr_mask = '0;
        step();
    endtask

    task automatic clear_all();
        pend_clr_valid = 1; pend_clr_mask = '1;
        step();
        pend_clr_valid = 0; pend_clr_mask = '0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin : watchdog
        #(150000 * 5);
        n_cmp++; n_bad++;
        $display("FAIL R6 watchdog act=timeout exp=completion");
        finish_run();
    end

    initial begin : stim
        repeat (2) @(posedge clk);
        cur_req = "R1";
        repeat (3) step();
        rst_n = 1;
        step();

        // R2 R3: lines 0..7 edge, rise then hold then fall
        cur_req = "R3";
        trig_edge = 16'h00FF;
        ppi_line = 16'hFFFF; step(); step();
        ppi_line = 16'h0000; step();
        // R4: level lines 8..15 toggle without latching
        cur_req = "R4";
        ppi_line = 16'hFF00; step(); ppi_line = 16'h0000; step(); step();

        // R5: clear, then set wins against same-edge clear
        cur_req = "R5";
        clear_all(); step();
        ppi_line = 16'h0001; pend_clr_valid = 1; pend_clr_mask = 32'h0001_0000;
        step();
        pend_clr_valid = 0; pend_clr_mask = '0; ppi_line = '0; step();

        // R7: SGI 3 is non-secure group 1
        cur_req = "R7";
        sec_off = 1; grp_bit = 16'h0008;
        sgi(3, 0, 0, 0); sgi(3, 3, 0, 0); sgi(3, 2, 0, 0);
        // R8: SGI 5 group 0 takes a secure group 1 ask; SGI 6 secure group 1
        cur_req = "R8";
        grp_mod = 16'h0040;
        sgi(5, 1, 0, 0); sgi(6, 0, 0, 0); sgi(6, 1, 0, 0); sgi(5, 2, 0, 0);
        // R10 with R5: accepted set beats a clear of the same bit
        cur_req = "R10";
        clear_all();
        sgi(5, 0, 0, 1); sgi(6, 1, 0, 0);

        // R9: access levels 0..3 for group 0 (SGI 1) and secure group 1 (SGI 2)
        cur_req = "R9";
        sec_off = 0; grp_bit = 16'h0008; grp_mod = 16'h0004;
        for (int lv = 0; lv < 4; lv++) begin
            clear_all();
            sgi_ns_acc = '0;
            sgi_ns_acc[3:2] = 2'(lv); sgi_ns_acc[5:4] = 2'(lv);
            sgi(1, 0, 1, 0); sgi(2, 1, 1, 0);
        end
        sgi_ns_acc = '0;
        sgi(3, 2, 1, 0);          // non-secure group 1 skips the check
        sgi(1, 0, 0, 0);          // secure side skips the check
        sec_off = 1; sgi(2, 1, 1, 0);

        // R6: back-to-back requests
        cur_req = "R6";
        clear_all();
        for (int k = 0; k < 6; k++) begin
            sgi_valid = 1; sgi_id = 4'(k); sgi_grp = 2'(k % 3); sgi_ns = k[0];
            step();
        end
        sgi_valid = 0; step(); step(); step();

        // R1: reset mid-run
        cur_req = "R1";
        ppi_line = 16'h00F0; step();
        rst_n = 0; step(); step(); rst_n = 1; step();

        // Mixed random traffic
        cur_req = "R3 R5 R7 R9 R10";
        for (int c = 0; c < 3000; c++) begin
            ppi_line       = 16'($urandom);
            trig_edge      = (c % 500 == 0) ? 16'($urandom) : trig_edge;
            grp_bit        = 16'($urandom);
            grp_mod        = 16'($urandom);
            sgi_ns_acc     = $urandom;
            sec_off        = ($urandom % 4) == 0;
            sgi_valid      = ($urandom % 3) != 0;
            sgi_id         = 4'($urandom);
            sgi_grp        = 2'($urandom);
            sgi_ns         = 1'($urandom);
            pend_clr_valid = ($urandom % 4) == 0;
            pend_clr_mask  = $urandom;
            step();
        end
        sgi_valid = 0; pend_clr_valid = 0;
        step(); step(); step();
        finish_run();
    end

endmodule